// File: doc/BRIEF.md
# Quarter-Duty Single-Wire Bit Encoder

This block turns a stream of bytes into a self-clocked waveform on one wire. Every bit occupies a frame made of four quarter slots of equal length. The first slot is always high, so each frame opens with a rising edge. The last slot is always low. The two middle slots carry the bit value: a one gives the slot pattern 1110 and a zero gives 1000. A receiver can recover both the timing and the data by finding each rising edge and checking whether the line is still high at the middle of the frame.

Bytes enter through a valid/ready handshake and leave most significant bit first. A divider input sets the bit period in system clocks. The quarter-slot length is the divider divided by four, and the block captures it when it accepts a byte. A new byte can be accepted in the final clock of the previous byte's last frame, so consecutive bytes follow each other with no gap. When nothing is pending the line rests low and the busy flag is low.

Top module: `qd_wire_encoder`

## Requirements
- R1: While reset is asserted, and on the first clock after reset, `line_out` and `busy` are low and `in_ready` is high.
- R2: Every bit frame starts with `line_out` high in its first quarter slot. The last slot of the previous frame, or the idle state, is low, so each frame opens with a rising edge.
- R3: A data bit of 1 drives slot levels high, high, high, low (1110) in the four slots of its frame.
- R4: A data bit of 0 drives slot levels high, low, low, low (1000) in the four slots of its frame.
- R5: The bits of a byte are sent most significant first. Bit DATA_W-1 uses the first frame and bit 0 uses the last.
- R6: Each quarter slot lasts Q clocks, where Q = floor(div_cfg / 4). When that quotient is 0, Q is 1. A bit frame therefore lasts 4*Q clocks.
- R7: Q is captured on the clock edge that accepts a byte. Changing `div_cfg` later has no effect on that byte's waveform.
- R8: `in_ready` is high in the final clock of the last frame of a byte. A byte accepted on that edge starts its first frame on the very next clock, with no idle clock between the two bytes.
- R9: `busy` rises on the clock after a byte is accepted. It falls right after the final low quarter of the last pending byte, and from then on `line_out` stays low.
- R10: While a byte is in flight, `in_ready` is low except in its final clock. Any `in_valid` pulse during those clocks is ignored and leaves `line_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_cfg | input | DIV_W | Bit period in system clocks, captured per byte |
| in_valid | input | 1 | Byte offered for transmission |
| in_data | input | DATA_W | Byte to transmit, MSB sent first |
| in_ready | output | 1 | Block accepts a byte on this clock edge |
| line_out | output | 1 | Single-wire drive level |
| busy | output | 1 | A frame is in progress |

## Verification
The bench uses the default widths (8-bit bytes, 16-bit divider) and changes `div_cfg` between runs. A divider of 2 exercises the clamp to a one-clock quarter. A divider of 4 gives the fastest legal rate, where `in_ready` and the slot boundaries fall on consecutive clocks. A divider of 13 exercises the truncation of a remainder, and a divider of 16 gives long slots, which leave room to change the divider and pulse `in_valid` in the middle of a byte. Back-to-back bytes of all ones, all zeros and mixed patterns check that the low tail of one frame joins the rising head of the next.

// File: rtl/qd_pkg.sv
package qd_pkg;

    // Quarter slots within one bit frame, in transmission order.
    typedef enum logic [1:0] {
        SLOT_HEAD  = 2'd0,
        SLOT_MID_A = 2'd1,
        SLOT_MID_B = 2'd2,
        SLOT_TAIL  = 2'd3
    } slot_e;

    // Wire level for a given slot: head high, tail low, middle slots carry data.
    function automatic logic slot_level(input slot_e slot, input logic data_bit);
        logic lvl;
        case (slot)
            SLOT_HEAD:  lvl = 1'b1;
            SLOT_MID_A: lvl = data_bit;
            SLOT_MID_B: lvl = data_bit;
            default:    lvl = 1'b0;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/qd_tick_gen.sv
module qd_tick_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] qlen_in,
    output logic             tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] qlen;
    } tick_st_t;

    tick_st_t st_q, st_d;
    logic     at_end;

    assign at_end = (st_q.cnt == st_q.qlen - CNT_W'(1));
    assign tick   = run && at_end;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt  = '0;
            st_d.qlen = qlen_in;
        end else if (run) begin
            if (at_end) st_d.cnt = '0;
            else        st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt  <= '0;
            st_q.qlen <= CNT_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    // R6: the slot counter never passes the latched quarter length
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (st_q.cnt < st_q.qlen));

endmodule

// File: rtl/qd_slot_seq.sv
module qd_slot_seq
    import qd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              tick,
    output logic              active,
    output slot_e             slot,
    output logic              cur_bit,
    output logic              last_slot
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        logic              active;
        slot_e             slot;
        logic [IDX_W-1:0]  bidx;
        logic [DATA_W-1:0] shreg;
    } seq_st_t;

    seq_st_t st_q, st_d;

    assign active    = st_q.active;
    assign slot      = st_q.slot;
    assign cur_bit   = st_q.shreg[DATA_W-1];
    assign last_slot = st_q.active && (st_q.slot == SLOT_TAIL) && (st_q.bidx == '0);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.active = 1'b1;
            st_d.slot   = SLOT_HEAD;
            st_d.bidx   = IDX_W'(DATA_W - 1);
            st_d.shreg  = load_data;
        end else if (st_q.active && tick) begin
            if (st_q.slot == SLOT_TAIL) begin
                st_d.slot = SLOT_HEAD;
                if (st_q.bidx == '0) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.bidx  = st_q.bidx - IDX_W'(1);
                    st_d.shreg = {st_q.shreg[DATA_W-2:0], 1'b0};
                end
            end else begin
                st_d.slot = slot_e'(st_q.slot + 2'd1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.active <= 1'b0;
            st_q.slot   <= SLOT_HEAD;
            st_q.bidx   <= '0;
            st_q.shreg  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: a slot is held until the quarter tick arrives
    a_r6_slot_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q.active && !tick && !load) |=> $stable(st_q.slot));

    // R5: within a byte the shift register only moves at a frame boundary
    a_r5_shift_at_tail: assert property (@(posedge clk) disable iff (rst)
        (st_q.active && !load && !(tick && st_q.slot == SLOT_TAIL)) |=> $stable(st_q.shreg));

endmodule

// File: rtl/qd_slot_mux.sv
module qd_slot_mux
    import qd_pkg::*;
(
    input  logic  active,
    input  slot_e slot,
    input  logic  data_bit,
    output logic  level
);

    always_comb begin
        level = active ? slot_level(slot, data_bit) : 1'b0;
    end

endmodule

// File: rtl/qd_wire_encoder.sv
module qd_wire_encoder
    import qd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              line_out,
    output logic              busy
);

    logic             tick;
    logic             accept;
    logic             active;
    logic             cur_bit;
    logic             last_slot;
    slot_e            slot;
    logic [DIV_W-1:0] qlen_raw;
    logic [DIV_W-1:0] qlen;

    // Quarter length: divider over four, never below one clock.
    assign qlen_raw = div_cfg >> 2;
    assign qlen     = (qlen_raw == '0) ? DIV_W'(1) : qlen_raw;

    assign in_ready = !active || (tick && last_slot);
    assign accept   = in_valid && in_ready;
    assign busy     = active;

    qd_tick_gen #(.CNT_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .run     (active),
        .qlen_in (qlen),
        .tick    (tick)
    );

    qd_slot_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_data (in_data),
        .tick      (tick),
        .active    (active),
        .slot      (slot),
        .cur_bit   (cur_bit),
        .last_slot (last_slot)
    );

    qd_slot_mux u_mux (
        .active   (active),
        .slot     (slot),
        .data_bit (cur_bit),
        .level    (line_out)
    );

    // R8: an accepted byte starts its head slot on the next clock
    a_r8_start_next: assert property (@(posedge clk) disable iff (rst)
        accept |=> (busy && line_out));

    // R9: the line rests low whenever nothing is in flight
    a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !line_out);

    // R10: no acceptance in the middle of a byte
    a_r10_no_mid_accept: assert property (@(posedge clk) disable iff (rst)
        (busy && !last_slot) |-> !in_ready);

    // R2: a new transmission opens with the line high
    a_r2_open_high: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> line_out);

endmodule

// File: tb/qd_wire_encoder_test.sv
module qd_wire_encoder_test;

    localparam int DATA_W = 8;
    localparam int DIV_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DIV_W-1:0]  div_cfg = 16'd8;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_ready;
    logic              line_out;
    logic              busy;

    int    n_cmp  = 0;
    int    n_bad  = 0;
    int    cycles = 0;
    string tag    = "R1";
    logic  exp_q[$];

    always #4 clk = ~clk;

    qd_wire_encoder #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uut (
        .clk      (clk),
        .rst      (rst),
        .div_cfg  (div_cfg),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .line_out (line_out),
        .busy     (busy)
    );

    function automatic void push_byte(input logic [DATA_W-1:0] d, input int dv);
        int q = dv / 4;
        if (q == 0) q = 1;
        for (int b = DATA_W - 1; b >= 0; b--)
            for (int s = 0; s < 4; s++)
                for (int k = 0; k < q; k++)
                    exp_q.push_back((s == 0) ? 1'b1 : (s == 3) ? 1'b0 : d[b]);
    endfunction

    task automatic check(input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // Reference model, evaluated mid-cycle once the inputs are settled.
    always @(negedge clk) begin
        #2;
        if (rst) begin
            exp_q.delete();
        end else begin
            logic exp_ready;
            exp_ready = (exp_q.size() <= 1);
            check("line_out (R2 R3 R4 R5)", line_out, (exp_q.size() != 0) ? exp_q[0] : 1'b0);
            check("busy (R9)", busy, exp_q.size() != 0);
            check("in_ready (R8 R10)", in_ready, exp_ready);
            if (exp_q.size() != 0) void'(exp_q.pop_front());
            if (in_valid && exp_ready) push_byte(in_data, int'(div_cfg));
        end
    end

    // Offer a byte at a falling edge and return at the falling edge after acceptance.
    task automatic send(input logic [DATA_W-1:0] d);
        in_valid = 1'b1;
        in_data  = d;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
    endtask

    task automatic drain();
        in_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #3;
        tag = "R1";
        check("reset line_out", line_out, 1'b0);
        check("reset busy", busy, 1'b0);
        check("reset in_ready", in_ready, 1'b1);
        @(negedge clk);

        // Single mixed byte, Q=2 (R3, R4, R5)
        tag = "R3 R4 R5 R6";
        div_cfg = 16'd8;
        send(8'hA5);
        drain();

        // Back-to-back bytes with a remainder in the divider, Q=3 (R8)
        tag = "R8 R6";
        div_cfg = 16'd13;
        send(8'h00);
        send(8'hFF);
        send(8'h5A);
        drain();

        // Clamp to one-clock quarter (R6) and fastest back-to-back
        tag = "R6 R8 R2";
        div_cfg = 16'd2;
        send(8'h81);
        send(8'h7E);
        div_cfg = 16'd4;
        send(8'hC3);
        drain();

        // Divider changes in the middle of a byte (R7)
        tag = "R7";
        div_cfg = 16'd16;
        send(8'h3C);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        div_cfg = 16'd4;
        drain();

        // Offers while a byte is in flight are ignored (R10)
        tag = "R10";
        div_cfg = 16'd8;
        send(8'h96);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'hFF;
        repeat (6) @(negedge clk);
        in_valid = 1'b0;
        drain();

        // Reset in the middle of a frame returns to idle (R1, R9)
        tag = "R1 R9";
        div_cfg = 16'd12;
        send(8'hE7);
        in_valid = 1'b0;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #3;
        check("post-reset line_out", line_out, 1'b0);
        check("post-reset busy", busy, 1'b0);
        @(negedge clk);
        send(8'h01);
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule